// File: doc/BRIEF.md
# Doorbell Mailbox Channel Unit

This block lets one processor ring doorbells in another. Each of the parameterised number of channels holds a 32-bit flag word. The sending agent reaches the unit through its own register port, called the sender frame, and ORs bits into a flag word. The receiving agent uses a second register port, the receiver frame. Through it the receiver reads each word, clears bits it has handled and masks bits it does not want to be interrupted by. Both ports are plain 32-bit register buses. A request is one cycle of valid, write enable, address and write data. One cycle later the port raises ready and, on a read, drives the read data.

The receiver gets one interrupt line per channel and a summary interrupt. The sender may ask for a per-channel acknowledge interrupt. It fires when the receiver drains a channel's flag word to zero. Both frames expose summary words with one bit per channel, so that software can find the lowest pending channel quickly. Before it rings, sender software raises an access request and polls access ready. Ready comes up a fixed, parameterised number of cycles after the request. The minor revision is a parameter: with revision 0 the per-channel sender interrupts and the summary words are absent.

Top module: `doorbell_mbox`

## Requirements
- R1: After reset all flag words, masks, interrupt enables, sender channel interrupt states and the access request read 0, and all interrupt outputs are low.
- R2: A sender write to window offset 0x0C of channel n (window base n*0x20) ORs the written bits into flag word n. Offset 0x00 of channel n reads the flag word in both frames.
- R3: A receiver write to window offset 0x08 clears the written bits of flag word n. If a sender set and a receiver clear reach the same channel in the same cycle, the cleared bits end up 0.
- R4: Receiver offsets 0x14 and 0x18 set and clear mask bits, and offset 0x10 reads the mask. Offset 0x04 reads flag AND NOT mask. `rcv_ch_irq_o[n]` is high exactly when that masked value is non-zero.
- R5: The sender channel interrupt state (offset 0x10, bit 0) becomes 1 in the cycle a receiver clear takes a non-zero flag word to zero. Writing bit 0 = 1 to offset 0x14 clears it. Offset 0x18 bit 0 is a read/write enable. `snd_ch_irq_o[n]` is state AND enable.
- R6: Summary word i at 0xFA0 + 4*i has bit j set when channel 32*i+j has its interrupt active: `rcv_ch_irq_o` in the receiver frame, `snd_ch_irq_o` in the sender frame.
- R7: 0xF80 reads NUM_CH in both frames. 0xFCC reads 0x1 in bits 7:4 and MINOR_REV in bits 3:0.
- R8: Writing 1 to bit 0 of sender 0xF88 raises the access request. 0xF8C bit 0 becomes 1 exactly READY_DELAY clock edges after the write edge. Writing 0 drops request and ready together at the write edge.
- R9: Interrupt status is read at 0xF90, cleared by a write to 0xF94 and enabled at 0xF98. Sender bit 0 is a sticky event set when access ready rises. Bit 2 in both frames is the OR of that frame's channel interrupts. Each frame's interrupt output is the OR of status AND enable.
- R10: Reserved offsets, unused channel windows and write-only registers read 0. Writes to read-only or reserved locations change no state.
- R11: With MINOR_REV = 0, sender offsets 0x10 to 0x18, the summary words, status bit 2 and the receiver enable read 0 and ignore writes.
- R12: Ready rises in the cycle after each request, with read data valid in that cycle. A write takes effect at the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| snd_valid_i | input | 1 | Sender frame request |
| snd_we_i | input | 1 | Sender frame write enable |
| snd_addr_i | input | 12 | Sender frame byte address |
| snd_wdata_i | input | 32 | Sender frame write data |
| snd_ready_o | output | 1 | Sender frame response strobe |
| snd_rdata_o | output | 32 | Sender frame read data |
| rcv_valid_i | input | 1 | Receiver frame request |
| rcv_we_i | input | 1 | Receiver frame write enable |
| rcv_addr_i | input | 12 | Receiver frame byte address |
| rcv_wdata_i | input | 32 | Receiver frame write data |
| rcv_ready_o | output | 1 | Receiver frame response strobe |
| rcv_rdata_o | output | 32 | Receiver frame read data |
| snd_irq_o | output | 1 | Sender frame interrupt |
| rcv_irq_o | output | 1 | Receiver frame interrupt |
| snd_ch_irq_o | output | NUM_CH | Per-channel sender acknowledge interrupts |
| rcv_ch_irq_o | output | NUM_CH | Per-channel receiver interrupts |

## Verification
The hardest situation to reach is a sender set and a receiver clear landing on the same flag word in the same edge. The two frames are independent buses, so random traffic almost never lines them up. The bench therefore drives both ports at the same falling edge on purpose, with overlapping bit patterns, and compares the result with the clear-wins rule. The acknowledge interrupt needs a word to drain to exactly zero. For that, half of the random receiver clears write all ones, and a reference model tracks every drain.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned WIN_BYTES = 32;
  localparam int unsigned MAX_CH    = 124;
  localparam int unsigned COMB_W    = 128;

  // window word offsets, sender side
  localparam logic [2:0] SOFF_STAT  = 3'd0;
  localparam logic [2:0] SOFF_SET   = 3'd3;
  localparam logic [2:0] SOFF_CIST  = 3'd4;
  localparam logic [2:0] SOFF_CICLR = 3'd5;
  localparam logic [2:0] SOFF_CIEN  = 3'd6;
  // window word offsets, receiver side
  localparam logic [2:0] ROFF_STAT  = 3'd0;
  localparam logic [2:0] ROFF_MSTAT = 3'd1;
  localparam logic [2:0] ROFF_CLR   = 3'd2;
  localparam logic [2:0] ROFF_MASK  = 3'd4;
  localparam logic [2:0] ROFF_MSET  = 3'd5;
  localparam logic [2:0] ROFF_MCLR  = 3'd6;

  // global word addresses (byte address >> 2)
  localparam logic [9:0] WA_CFG   = 10'h3E0;
  localparam logic [9:0] WA_REQ   = 10'h3E2;
  localparam logic [9:0] WA_RDY   = 10'h3E3;
  localparam logic [9:0] WA_IST   = 10'h3E4;
  localparam logic [9:0] WA_ICLR  = 10'h3E5;
  localparam logic [9:0] WA_IEN   = 10'h3E6;
  localparam logic [9:0] WA_COMB0 = 10'h3E8;
  localparam logic [9:0] WA_AID   = 10'h3F3;

  localparam int unsigned IST_EVT_BIT  = 0;
  localparam int unsigned IST_COMB_BIT = 2;
  localparam logic [3:0]  MAJOR_REV    = 4'h1;
endpackage

// File: rtl/doorbell_access.sv
module doorbell_access #(
  parameter int unsigned DELAY = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic val_i,
  output logic req_o,
  output logic rdy_o,
  output logic rise_o
);
  localparam int unsigned CNT_W = (DELAY < 2) ? 1 : $clog2(DELAY + 1);

  logic             req_q, rdy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             drop, last;

  assign drop   = wr_i & ~val_i;
  assign last   = (cnt_q == CNT_W'(DELAY - 1));
  assign rise_o = req_q & ~rdy_q & last & ~drop;
  assign req_o  = req_q;
  assign rdy_o  = rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      rdy_q <= 1'b0;
      cnt_q <= '0;
    end else if (drop) begin
      req_q <= 1'b0;
      rdy_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (wr_i) req_q <= 1'b1;
      if (req_q && !rdy_q) begin
        if (last) rdy_q <= 1'b1;
        else      cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/doorbell_chan.sv
module doorbell_chan #(
  parameter bit HAS_CH_INT = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        set_we_i,
  input  logic [31:0] set_bits_i,
  input  logic        clr_we_i,
  input  logic [31:0] clr_bits_i,
  input  logic        mset_we_i,
  input  logic        mclr_we_i,
  input  logic [31:0] mbits_i,
  input  logic        cien_we_i,
  input  logic        cien_i,
  input  logic        ciclr_we_i,
  input  logic        ciclr_i,
  output logic [31:0] flag_o,
  output logic [31:0] mask_o,
  output logic        rcv_irq_o,
  output logic        snd_ist_o,
  output logic        snd_ien_o,
  output logic        snd_irq_o
);
  logic [31:0] flag_q, flag_d, mask_q;
  logic        drain;

  // clear applied after set: clear wins on overlap
  assign flag_d = (flag_q | (set_we_i ? set_bits_i : '0)) & ~(clr_we_i ? clr_bits_i : '0);
  assign drain  = (flag_q != '0) && (flag_d == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      flag_q <= flag_d;
      if (mset_we_i)      mask_q <= mask_q | mbits_i;
      else if (mclr_we_i) mask_q <= mask_q & ~mbits_i;
    end
  end

  assign flag_o    = flag_q;
  assign mask_o    = mask_q;
  assign rcv_irq_o = |(flag_q & ~mask_q);

  if (HAS_CH_INT) begin : g_ch_int
    logic ist_q, ien_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ist_q <= 1'b0;
        ien_q <= 1'b0;
      end else begin
        if (drain)                      ist_q <= 1'b1;
        else if (ciclr_we_i && ciclr_i) ist_q <= 1'b0;
        if (cien_we_i)                  ien_q <= cien_i;
      end
    end
    assign snd_ist_o = ist_q;
    assign snd_ien_o = ien_q;
  end else begin : g_no_ch_int
    logic unused;
    assign unused    = drain ^ cien_we_i ^ cien_i ^ ciclr_we_i ^ ciclr_i;
    assign snd_ist_o = 1'b0;
    assign snd_ien_o = 1'b0;
  end

  assign snd_irq_o = snd_ist_o & snd_ien_o;
endmodule

// File: rtl/doorbell_mbox.sv
module doorbell_mbox
  import doorbell_pkg::*;
#(
  parameter int unsigned NUM_CH      = 40,
  parameter int unsigned READY_DELAY = 3,
  parameter int unsigned MINOR_REV   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              snd_valid_i,
  input  logic              snd_we_i,
  input  logic [11:0]       snd_addr_i,
  input  logic [31:0]       snd_wdata_i,
  output logic              snd_ready_o,
  output logic [31:0]       snd_rdata_o,
  input  logic              rcv_valid_i,
  input  logic              rcv_we_i,
  input  logic [11:0]       rcv_addr_i,
  input  logic [31:0]       rcv_wdata_i,
  output logic              rcv_ready_o,
  output logic [31:0]       rcv_rdata_o,
  output logic              snd_irq_o,
  output logic              rcv_irq_o,
  output logic [NUM_CH-1:0] snd_ch_irq_o,
  output logic [NUM_CH-1:0] rcv_ch_irq_o
);
  localparam int unsigned CH_SPAN   = NUM_CH * WIN_BYTES;
  localparam bit          HAS_CI    = (MINOR_REV == 1);
  localparam logic [2:0]  SIEN_MASK = HAS_CI ? 3'b101 : 3'b001;
  localparam logic [31:0] AID_VAL   = {24'b0, MAJOR_REV, 4'(MINOR_REV)};

  // sender decode
  logic       s_hit, s_wr, s_rd, s_win;
  logic [6:0] s_ch;
  logic [2:0] s_off;
  logic [9:0] s_wa;
  assign s_hit = snd_valid_i & (snd_addr_i[1:0] == 2'b00);
  assign s_wr  = s_hit & snd_we_i;
  assign s_rd  = s_hit & ~snd_we_i;
  assign s_win = (snd_addr_i < 12'(CH_SPAN));
  assign s_ch  = snd_addr_i[11:5];
  assign s_off = snd_addr_i[4:2];
  assign s_wa  = snd_addr_i[11:2];

  // receiver decode
  logic       r_hit, r_wr, r_rd, r_win;
  logic [6:0] r_ch;
  logic [2:0] r_off;
  logic [9:0] r_wa;
  assign r_hit = rcv_valid_i & (rcv_addr_i[1:0] == 2'b00);
  assign r_wr  = r_hit & rcv_we_i;
  assign r_rd  = r_hit & ~rcv_we_i;
  assign r_win = (rcv_addr_i < 12'(CH_SPAN));
  assign r_ch  = rcv_addr_i[11:5];
  assign r_off = rcv_addr_i[4:2];
  assign r_wa  = rcv_addr_i[11:2];

  // channel array
  logic [31:0]          flag_w [NUM_CH];
  logic [31:0]          mask_w [NUM_CH];
  logic [NUM_CH-1:0]    ch_ist, ch_ien;
  logic [NUM_CH*32-1:0] flag_flat;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic s_sel, r_sel;
    assign s_sel = s_wr & s_win & (s_ch == 7'(n));
    assign r_sel = r_wr & r_win & (r_ch == 7'(n));
    doorbell_chan #(.HAS_CH_INT(HAS_CI)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_we_i   (s_sel & (s_off == SOFF_SET)),
      .set_bits_i (snd_wdata_i),
      .clr_we_i   (r_sel & (r_off == ROFF_CLR)),
      .clr_bits_i (rcv_wdata_i),
      .mset_we_i  (r_sel & (r_off == ROFF_MSET)),
      .mclr_we_i  (r_sel & (r_off == ROFF_MCLR)),
      .mbits_i    (rcv_wdata_i),
      .cien_we_i  (s_sel & (s_off == SOFF_CIEN)),
      .cien_i     (snd_wdata_i[0]),
      .ciclr_we_i (s_sel & (s_off == SOFF_CICLR)),
      .ciclr_i    (snd_wdata_i[0]),
      .flag_o     (flag_w[n]),
      .mask_o     (mask_w[n]),
      .rcv_irq_o  (rcv_ch_irq_o[n]),
      .snd_ist_o  (ch_ist[n]),
      .snd_ien_o  (ch_ien[n]),
      .snd_irq_o  (snd_ch_irq_o[n])
    );
    assign flag_flat[n*32 +: 32] = flag_w[n];
  end

  // summary words
  logic [COMB_W-1:0] s_comb, r_comb;
  assign s_comb = HAS_CI ? COMB_W'(snd_ch_irq_o) : '0;
  assign r_comb = HAS_CI ? COMB_W'(rcv_ch_irq_o) : '0;

  // access handshake
  logic acc_req, acc_rdy, acc_rise;
  doorbell_access #(.DELAY(READY_DELAY)) u_access (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (s_wr & ~s_win & (s_wa == WA_REQ)),
    .val_i  (snd_wdata_i[0]),
    .req_o  (acc_req),
    .rdy_o  (acc_rdy),
    .rise_o (acc_rise)
  );

  // interrupt status / enable
  logic       evt_q, rien_q;
  logic [2:0] sien_q, s_ist, r_ist;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q  <= 1'b0;
      sien_q <= '0;
      rien_q <= 1'b0;
    end else begin
      if (acc_rise)
        evt_q <= 1'b1;
      else if (s_wr && !s_win && s_wa == WA_ICLR && snd_wdata_i[IST_EVT_BIT])
        evt_q <= 1'b0;
      if (s_wr && !s_win && s_wa == WA_IEN)
        sien_q <= snd_wdata_i[2:0] & SIEN_MASK;
      if (r_wr && !r_win && r_wa == WA_IEN)
        rien_q <= rcv_wdata_i[IST_COMB_BIT] & HAS_CI;
    end
  end

  assign s_ist     = {HAS_CI & (|snd_ch_irq_o), 1'b0, evt_q};
  assign r_ist     = {HAS_CI & (|rcv_ch_irq_o), 2'b00};
  assign snd_irq_o = |(s_ist & sien_q);
  assign rcv_irq_o = r_ist[IST_COMB_BIT] & rien_q;

  // read muxes
  logic [31:0] s_rval, r_rval;

  always_comb begin
    s_rval = '0;
    if (s_win) begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (s_ch == 7'(n)) begin
          case (s_off)
            SOFF_STAT: s_rval = flag_w[n];
            SOFF_CIST: s_rval = {31'b0, ch_ist[n]};
            SOFF_CIEN: s_rval = {31'b0, ch_ien[n]};
            default:   s_rval = '0;
          endcase
        end
      end
    end else begin
      case (s_wa)
        WA_CFG:  s_rval = 32'(NUM_CH);
        WA_REQ:  s_rval = {31'b0, acc_req};
        WA_RDY:  s_rval = {31'b0, acc_rdy};
        WA_IST:  s_rval = {29'b0, s_ist};
        WA_IEN:  s_rval = {29'b0, sien_q};
        WA_AID:  s_rval = AID_VAL;
        default: if (s_wa[9:2] == WA_COMB0[9:2]) s_rval = s_comb[{s_wa[1:0], 5'b0} +: 32];
      endcase
    end
  end

  always_comb begin
    r_rval = '0;
    if (r_win) begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (r_ch == 7'(n)) begin
          case (r_off)
            ROFF_STAT:  r_rval = flag_w[n];
            ROFF_MSTAT: r_rval = flag_w[n] & ~mask_w[n];
            ROFF_MASK:  r_rval = mask_w[n];
            default:    r_rval = '0;
          endcase
        end
      end
    end else begin
      case (r_wa)
        WA_CFG:  r_rval = 32'(NUM_CH);
        WA_IST:  r_rval = {29'b0, r_ist};
        WA_IEN:  r_rval = {29'b0, rien_q, 2'b00};
        WA_AID:  r_rval = AID_VAL;
        default: if (r_wa[9:2] == WA_COMB0[9:2]) r_rval = r_comb[{r_wa[1:0], 5'b0} +: 32];
      endcase
    end
  end

  // response stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snd_ready_o <= 1'b0;
      snd_rdata_o <= '0;
      rcv_ready_o <= 1'b0;
      rcv_rdata_o <= '0;
    end else begin
      snd_ready_o <= snd_valid_i;
      snd_rdata_o <= s_rd ? s_rval : '0;
      rcv_ready_o <= rcv_valid_i;
      rcv_rdata_o <= r_rd ? r_rval : '0;
    end
  end
endmodule

// File: rtl/doorbell_mbox_chk.sv
module doorbell_mbox_chk #(
  parameter int unsigned NUM_CH = 40
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                snd_valid_i,
  input logic                snd_we_i,
  input logic                rcv_valid_i,
  input logic                rcv_we_i,
  input logic                snd_ready_i,
  input logic                rcv_ready_i,
  input logic                rcv_irq_i,
  input logic [NUM_CH-1:0]   rcv_ch_irq_i,
  input logic [NUM_CH*32-1:0] flag_all_i,
  input logic                acc_req_i,
  input logic                acc_rdy_i
);
  assert_snd_ready_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snd_valid_i |=> snd_ready_i);
  assert_rcv_ready_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rcv_valid_i |=> rcv_ready_i);
  assert_snd_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snd_valid_i |=> !snd_ready_i);
  assert_flag_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flag_all_i & ~$past(flag_all_i))) |-> $past(snd_valid_i && snd_we_i));
  assert_flag_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(flag_all_i) & ~flag_all_i)) |-> $past(rcv_valid_i && rcv_we_i));
  assert_rdy_needs_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_rdy_i |-> acc_req_i);
  assert_withdraw_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(acc_req_i) |-> !acc_rdy_i);
  assert_rcv_irq_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rcv_irq_i |-> (|rcv_ch_irq_i));
endmodule

bind doorbell_mbox doorbell_mbox_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .snd_valid_i  (snd_valid_i),
  .snd_we_i     (snd_we_i),
  .rcv_valid_i  (rcv_valid_i),
  .rcv_we_i     (rcv_we_i),
  .snd_ready_i  (snd_ready_o),
  .rcv_ready_i  (rcv_ready_o),
  .rcv_irq_i    (rcv_irq_o),
  .rcv_ch_irq_i (rcv_ch_irq_o),
  .flag_all_i   (flag_flat),
  .acc_req_i    (acc_req),
  .acc_rdy_i    (acc_rdy)
);

// File: tb/doorbell_mbox_tb_top.sv
module doorbell_mbox_tb_top;
  localparam int unsigned NCH = 40;
  localparam int unsigned DLY = 3;
  localparam int unsigned ZCH = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic s_valid = 0, s_we = 0, r_valid = 0, r_we = 0;
  logic [11:0] s_addr = 0, r_addr = 0;
  logic [31:0] s_wdata = 0, r_wdata = 0;
  logic s_ready, r_ready, s_irq, r_irq;
  logic [31:0] s_rdata, r_rdata;
  logic [NCH-1:0] s_ch_irq, r_ch_irq;

  doorbell_mbox #(.NUM_CH(NCH), .READY_DELAY(DLY), .MINOR_REV(1)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .snd_valid_i(s_valid), .snd_we_i(s_we), .snd_addr_i(s_addr), .snd_wdata_i(s_wdata),
    .snd_ready_o(s_ready), .snd_rdata_o(s_rdata),
    .rcv_valid_i(r_valid), .rcv_we_i(r_we), .rcv_addr_i(r_addr), .rcv_wdata_i(r_wdata),
    .rcv_ready_o(r_ready), .rcv_rdata_o(r_rdata),
    .snd_irq_o(s_irq), .rcv_irq_o(r_irq), .snd_ch_irq_o(s_ch_irq), .rcv_ch_irq_o(r_ch_irq));

  logic zs_valid = 0, zs_we = 0, zr_valid = 0, zr_we = 0;
  logic [11:0] zs_addr = 0, zr_addr = 0;
  logic [31:0] zs_wdata = 0, zr_wdata = 0;
  logic zs_ready, zr_ready, zs_irq, zr_irq;
  logic [31:0] zs_rdata, zr_rdata;
  logic [ZCH-1:0] zs_ch_irq, zr_ch_irq;

  doorbell_mbox #(.NUM_CH(ZCH), .READY_DELAY(2), .MINOR_REV(0)) dut_r0_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .snd_valid_i(zs_valid), .snd_we_i(zs_we), .snd_addr_i(zs_addr), .snd_wdata_i(zs_wdata),
    .snd_ready_o(zs_ready), .snd_rdata_o(zs_rdata),
    .rcv_valid_i(zr_valid), .rcv_we_i(zr_we), .rcv_addr_i(zr_addr), .rcv_wdata_i(zr_wdata),
    .rcv_ready_o(zr_ready), .rcv_rdata_o(zr_rdata),
    .snd_irq_o(zs_irq), .rcv_irq_o(zr_irq), .snd_ch_irq_o(zs_ch_irq), .rcv_ch_irq_o(zr_ch_irq));

  int n_chk = 0, n_err = 0;
  logic [31:0] exp_flag [NCH];
  logic [31:0] exp_mask [NCH];
  logic        exp_ist  [NCH];
  logic        exp_ien  [NCH];
  logic        exp_evt;
  logic [2:0]  exp_sien;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input bit rcv, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    if (rcv) begin r_valid = 1; r_we = 1; r_addr = a; r_wdata = d; end
    else     begin s_valid = 1; s_we = 1; s_addr = a; s_wdata = d; end
    @(negedge clk_i);
    r_valid = 0; r_we = 0; s_valid = 0; s_we = 0;
  endtask

  task automatic rd(input bit rcv, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    if (rcv) begin r_valid = 1; r_we = 0; r_addr = a; end
    else     begin s_valid = 1; s_we = 0; s_addr = a; end
    @(negedge clk_i);
    r_valid = 0; s_valid = 0;
    chk("R12 ready", {31'b0, rcv ? r_ready : s_ready}, 32'd1);
    d = rcv ? r_rdata : s_rdata;
  endtask

  task automatic zwr(input bit rcv, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    if (rcv) begin zr_valid = 1; zr_we = 1; zr_addr = a; zr_wdata = d; end
    else     begin zs_valid = 1; zs_we = 1; zs_addr = a; zs_wdata = d; end
    @(negedge clk_i);
    zr_valid = 0; zr_we = 0; zs_valid = 0; zs_we = 0;
  endtask

  task automatic zrd(input bit rcv, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    if (rcv) begin zr_valid = 1; zr_we = 0; zr_addr = a; end
    else     begin zs_valid = 1; zs_we = 0; zs_addr = a; end
    @(negedge clk_i);
    zr_valid = 0; zs_valid = 0;
    d = rcv ? zr_rdata : zs_rdata;
  endtask

  function automatic logic rirq(input int c);
    return |(exp_flag[c] & ~exp_mask[c]);
  endfunction
  function automatic logic sirq(input int c);
    return exp_ist[c] & exp_ien[c];
  endfunction
  function automatic logic [31:0] comb_word(input bit rcv, input int w);
    logic [31:0] v = '0;
    for (int j = 0; j < 32; j++) begin
      if (w*32 + j < NCH) v[j] = rcv ? rirq(w*32 + j) : sirq(w*32 + j);
    end
    return v;
  endfunction
  function automatic logic any_r();
    logic a = 0;
    for (int c = 0; c < NCH; c++) a |= rirq(c);
    return a;
  endfunction
  function automatic logic any_s();
    logic a = 0;
    for (int c = 0; c < NCH; c++) a |= sirq(c);
    return a;
  endfunction

  task automatic check_chan(input int c);
    logic [31:0] d;
    logic [11:0] b = 12'(c * 32);
    rd(0, b + 12'h00, d); chk("R2 snd status", d, exp_flag[c]);
    rd(1, b + 12'h00, d); chk("R2 rcv status", d, exp_flag[c]);
    rd(1, b + 12'h04, d); chk("R4 masked", d, exp_flag[c] & ~exp_mask[c]);
    rd(1, b + 12'h10, d); chk("R4 mask", d, exp_mask[c]);
    rd(0, b + 12'h10, d); chk("R5 ch ist", d, {31'b0, exp_ist[c]});
    rd(0, b + 12'h18, d); chk("R5 ch ien", d, {31'b0, exp_ien[c]});
    chk("R4 rcv_ch_irq", {31'b0, r_ch_irq[c]}, {31'b0, rirq(c)});
    chk("R5 snd_ch_irq", {31'b0, s_ch_irq[c]}, {31'b0, sirq(c)});
  endtask

  task automatic check_global();
    logic [31:0] d;
    for (int w = 0; w < 2; w++) begin
      rd(1, 12'hFA0 + 12'(4*w), d); chk("R6 rcv comb", d, comb_word(1, w));
      rd(0, 12'hFA0 + 12'(4*w), d); chk("R6 snd comb", d, comb_word(0, w));
    end
    rd(1, 12'hF90, d); chk("R9 rcv ist", d, {29'b0, any_r(), 2'b0});
    rd(0, 12'hF90, d); chk("R9 snd ist", d, {29'b0, any_s(), 1'b0, exp_evt});
    chk("R9 rcv_irq", {31'b0, r_irq}, {31'b0, any_r()});
    chk("R9 snd_irq", {31'b0, s_irq},
        {31'b0, (exp_evt & exp_sien[0]) | (any_s() & exp_sien[2])});
  endtask

  initial begin
    logic [31:0] d, v, old;
    int cnt, c, op;
    void'($urandom(32'd1234));
    for (int i = 0; i < NCH; i++) begin
      exp_flag[i] = 0; exp_mask[i] = 0; exp_ist[i] = 0; exp_ien[i] = 0;
    end
    exp_evt = 0; exp_sien = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1 reset state
    chk("R12 idle ready", {31'b0, s_ready}, 32'd0);
    chk("R1 irq outputs", {s_ch_irq[31:0]} | {r_ch_irq[31:0]} | {30'b0, s_irq, r_irq}, 32'd0);
    rd(0, 12'h000, d);  chk("R1 flag", d, 0);
    rd(1, 12'h0B0, d);  chk("R1 mask", d, 0);
    rd(0, 12'hF88, d);  chk("R1 request", d, 0);
    rd(0, 12'hF98, d);  chk("R1 snd ien", d, 0);
    rd(0, 12'h018, d);  chk("R1 ch ien", d, 0);

    // R7 identification
    rd(0, 12'hF80, d); chk("R7 snd cfg", d, NCH);
    rd(1, 12'hF80, d); chk("R7 rcv cfg", d, NCH);
    rd(0, 12'hFCC, d); chk("R7 aid", d, 32'h11);
    rd(1, 12'hFCC, d); chk("R7 rcv aid", d, 32'h11);

    // R8/R9 access handshake
    wr(0, 12'hF98, 32'h1); exp_sien = 3'b001;
    wr(0, 12'hF88, 32'h1);
    rd(0, 12'hF8C, d); chk("R8 ready early", d, 0);
    rd(0, 12'hF8C, d); chk("R8 ready late", d, 1);
    exp_evt = 1;
    wr(0, 12'hF88, 32'h0);
    wr(0, 12'hF94, 32'h1); exp_evt = 0;
    wr(0, 12'hF88, 32'h1);
    cnt = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk_i); cnt++;
      if (s_irq) break;
    end
    chk("R8 ready delay", cnt, DLY);
    exp_evt = 1;
    rd(0, 12'hF90, d); chk("R9 ready event", d, 32'h1);
    wr(0, 12'hF88, 32'h0);
    rd(0, 12'hF8C, d); chk("R8 withdraw ready", d, 0);
    rd(0, 12'hF88, d); chk("R8 withdraw req", d, 0);
    chk("R9 evt sticky irq", {31'b0, s_irq}, 32'd1);
    wr(0, 12'hF94, 32'h1); exp_evt = 0;
    chk("R9 evt cleared irq", {31'b0, s_irq}, 32'd0);

    // enables for the rest
    wr(0, 12'hF98, 32'h7); exp_sien = 3'b101;
    wr(1, 12'hF98, 32'h4);
    rd(1, 12'hF98, d); chk("R9 rcv ien", d, 32'h4);

    // R2/R6 directed on channel 35 (word 1 bit 3)
    wr(0, 12'(35*32 + 12'h0C), 32'h0000_0101); exp_flag[35] = 32'h101;
    wr(0, 12'(35*32 + 12'h0C), 32'h8000_0000); exp_flag[35] |= 32'h8000_0000;
    check_chan(35);
    rd(1, 12'hFA4, d); chk("R6 word1 bit3", d, 32'h8);
    check_global();

    // R3 same-cycle set and clear on channel 3
    exp_flag[3] = 32'h0000_F000;
    wr(0, 12'(3*32 + 12'h0C), 32'h0000_F000);
    @(negedge clk_i);
    s_valid = 1; s_we = 1; s_addr = 12'(3*32 + 12'h0C); s_wdata = 32'h0F0F_0F0F;
    r_valid = 1; r_we = 1; r_addr = 12'(3*32 + 12'h08); r_wdata = 32'h00FF_F0FF;
    @(negedge clk_i);
    s_valid = 0; s_we = 0; r_valid = 0; r_we = 0;
    exp_flag[3] = (32'h0000_F000 | 32'h0F0F_0F0F) & ~32'h00FF_F0FF;
    check_chan(3);

    // R10 reserved and read-only
    rd(0, 12'h004, d); chk("R10 snd rsv 04", d, 0);
    rd(0, 12'h06C, d); chk("R10 set reads 0", d, 0);
    rd(1, 12'h068, d); chk("R10 clr reads 0", d, 0);
    rd(1, 12'h074, d); chk("R10 mset reads 0", d, 0);
    rd(0, 12'hF9C, d); chk("R10 rsv global", d, 0);
    wr(0, 12'(3*32), 32'hFFFF_FFFF);
    wr(0, 12'hF80, 32'h5);
    rd(0, 12'hF80, d); chk("R10 cfg ro", d, NCH);
    wr(0, 12'(50*32 + 12'h0C), 32'hFFFF_FFFF);
    rd(0, 12'(50*32), d); chk("R10 unused window", d, 0);
    check_chan(3);
    check_chan(18);

    // random traffic
    for (int it = 0; it < 300; it++) begin
      op = $urandom % 6;
      c  = $urandom % NCH;
      v  = $urandom;
      case (op)
        0: begin wr(0, 12'(c*32 + 12'h0C), v); exp_flag[c] |= v; end
        1: begin
          if ($urandom % 2) v = 32'hFFFF_FFFF;
          old = exp_flag[c];
          wr(1, 12'(c*32 + 12'h08), v);
          exp_flag[c] &= ~v;
          if (old != 0 && exp_flag[c] == 0) exp_ist[c] = 1;
        end
        2: begin v &= $urandom & $urandom; wr(1, 12'(c*32 + 12'h14), v); exp_mask[c] |= v; end
        3: begin wr(1, 12'(c*32 + 12'h18), v); exp_mask[c] &= ~v; end
        4: begin wr(0, 12'(c*32 + 12'h18), v); exp_ien[c] = v[0]; end
        default: begin wr(0, 12'(c*32 + 12'h14), v); if (v[0]) exp_ist[c] = 0; end
      endcase
      check_chan(c);
      if (it % 25 == 0) check_global();
    end
    check_global();

    // R11 revision 0 instance
    zrd(0, 12'hFCC, d); chk("R11 aid rev0", d, 32'h10);
    zwr(0, 12'h00C, 32'h3);
    zwr(0, 12'h018, 32'h1);
    zrd(0, 12'h018, d); chk("R11 ch ien absent", d, 0);
    zwr(1, 12'h008, 32'hFFFF_FFFF);
    zrd(0, 12'h010, d); chk("R11 ch ist absent", d, 0);
    zwr(0, 12'h00C, 32'h1);
    zrd(1, 12'hFA0, d); chk("R11 comb absent", d, 0);
    zwr(1, 12'hF98, 32'h4);
    zrd(1, 12'hF98, d); chk("R11 rcv ien absent", d, 0);
    zrd(1, 12'hF90, d); chk("R11 rcv ist absent", d, 0);
    chk("R11 rcv ch irq", {31'b0, zr_ch_irq[0]}, 32'd1);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule